// File: doc/BRIEF.md
# Programmable Sync Word Detector

This block is the receive framing path of a synchronous serial modem. Recovered data bits arrive one at a time, each marked by a valid strobe. The block shifts them into a 16-bit window. While the host has armed the hunt, it compares that window against a host-programmed sync word. It also compares the window against the bitwise complement of that word, so a channel with inverted polarity still locks.

On a match the block raises a sync-detect flag and an interrupt, and it disarms the hunt. It notes whether the complemented word was the one that matched. From the next bit onward it groups the stream into bytes, most significant bit first. For each completed byte it raises a receive-ready flag. A byte that is not taken in time is overwritten, and an overrun flag records the loss.

The host programs the sync word one byte at a time and arms or disarms the hunt through a control write. It reads a live status byte, and it uses two read strobes to acknowledge status and to take the receive byte. A sync word shorter than 16 bits is handled by filling its upper bits with an alternating 1010 preamble pattern before it is written. Driving the mode input to transmit clears all receive flags and stops bit intake.

Top module: `rx_sync_framer`

## Requirements
- R1: A write to address 0 loads the upper byte of the sync word and a write to address 1 loads the lower byte. The compared window holds the last 16 received bits, and the oldest of them lines up with word bit 15. A match found after arbitrary leading bits is still detected.
- R2: A window equal to the sync word or to its bitwise complement is a match. Status bit 3 reads 1 after a complement match and 0 after a true match.
- R3: Matching happens only while the prime bit is set (control write to address 2, data bit 0; seen as status bit 4). It also needs at least 16 bits received since arming. Without both, no sync is reported.
- R4: On a match, status bit 0 (sync detected) and irq_o are set, the prime bit clears, and status bit 5 (framing) is set.
- R5: A status read strobe clears status bit 0.
- R6: While framing, each group of 8 bits is assembled MSB first into rx_byte_o, and status bit 1 (receive ready) and irq_o are set.
- R7: Receive ready clears only once a data read strobe comes together with, or after, a status read made while it was set. A data read alone leaves it set.
- R8: If a byte completes while receive ready is still set and is not being consumed, status bit 2 (overrun) is set and the new byte replaces the old. A status read clears overrun.
- R9: A high tx_mode_i clears status bits 0, 1, 2 and 5, and while it is high received bits are ignored. A short sync word padded with the 1010 preamble in its upper bits is detected like any other 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_mode_i | input | 1 | 1 selects transmit, which clears receive flags |
| bit_valid_i | input | 1 | Strobe: bit_i carries a recovered bit |
| bit_i | input | 1 | Recovered serial bit |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | 0 sync high, 1 sync low, 2 control |
| wr_data_i | input | 8 | Host write data |
| rd_status_i | input | 1 | Status read strobe |
| rd_data_i | input | 1 | Receive byte read strobe |
| status_o | output | 8 | {2'b0, framing, prime, inverted, overrun, rx_ready, sync_det} |
| rx_byte_o | output | 8 | Receive buffer |
| irq_o | output | 1 | Sync detected or receive ready |

## Verification
The bench runs several word and stream pairs: exact matches, complement matches, a padded short word, and words off by one bit. A design that compared only one polarity, or got the inverted flag wrong, fails these. It arms on an all-zero word to catch a design that matches on a window still full of reset zeros, and it sends a matching word while unarmed or in transmit mode to catch hunting that is not gated. It reads data without reading status first, and it lets two bytes complete without a read. These catch a receive-ready flag that clears on a single read, a missed overrun, and a buffer that keeps the stale byte.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int unsigned ST_SYNC  = 0;
  localparam int unsigned ST_READY = 1;
  localparam int unsigned ST_OVR   = 2;
  localparam int unsigned ST_INV   = 3;
  localparam int unsigned ST_PRIME = 4;
  localparam int unsigned ST_FRAME = 5;

  typedef enum logic [1:0] {
    ADDR_SYNC_HI = 2'd0,
    ADDR_SYNC_LO = 2'd1,
    ADDR_CTRL    = 2'd2
  } host_addr_e;
endpackage

// File: rtl/sync_hunter.sv
module sync_hunter #(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic [WIN_W-1:0] word_i,
  output logic             match_o,
  output logic             inv_o
);
  localparam int unsigned FILL_W = $clog2(WIN_W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN_W);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(WIN_W - 1);

  logic [WIN_W-1:0]  win_q, win_next;
  logic [FILL_W-1:0] fill_q;
  logic              full;

  assign win_next = {win_q[WIN_W-2:0], bit_i};
  assign full     = fill_q >= FILL_LAST;
  assign inv_o    = win_next == ~word_i;
  assign match_o  = shift_i && full && ((win_next == word_i) || inv_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (arm_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      win_q <= win_next;
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  p_fill_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FILL_MAX);
  p_arm_restarts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (fill_q == '0));
endmodule

// File: rtl/byte_packer.sv
module byte_packer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] sh_q;

  assign done_o = shift_i && !clr_i && (cnt_q == CNT_LAST);
  assign byte_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= byte_o[BYTE_W-2:0];
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  p_byte_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/rx_sync_framer.sv
module rx_sync_framer
  import rsf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_mode_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_status_i,
  input  logic              rd_data_i,
  output logic [7:0]        status_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              irq_o
);
  localparam int unsigned SYNC_W = 2 * BYTE_W;

  logic [SYNC_W-1:0] word_q;
  logic [BYTE_W-1:0] buf_q;
  logic prime_q, framing_q, sync_q, ready_q, ovr_q, inv_q, seen_q;
  logic ctl_wr, arm, bit_ok, match, match_inv, done, consume;
  logic [BYTE_W-1:0] byte_w;

  assign ctl_wr  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign arm     = ctl_wr && wr_data_i[0];
  assign bit_ok  = bit_valid_i && !tx_mode_i;
  assign consume = rd_data_i && (seen_q || rd_status_i) && ready_q;

  sync_hunter #(.WIN_W(SYNC_W)) u_hunter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .shift_i (bit_ok && prime_q && !ctl_wr),
    .bit_i   (bit_i),
    .word_i  (word_q),
    .match_o (match),
    .inv_o   (match_inv)
  );

  byte_packer #(.BYTE_W(BYTE_W)) u_packer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!framing_q || tx_mode_i || ctl_wr),
    .shift_i (bit_ok && framing_q),
    .bit_i   (bit_i),
    .done_o  (done),
    .byte_o  (byte_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_SYNC_HI) word_q[SYNC_W-1:BYTE_W] <= wr_data_i;
      if (wr_addr_i == ADDR_SYNC_LO) word_q[BYTE_W-1:0]      <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prime_q   <= 1'b0;
      framing_q <= 1'b0;
      inv_q     <= 1'b0;
    end else begin
      if (ctl_wr)     prime_q <= wr_data_i[0];
      else if (match) prime_q <= 1'b0;
      if (tx_mode_i || ctl_wr) framing_q <= 1'b0;
      else if (match)          framing_q <= 1'b1;
      if (arm)        inv_q <= 1'b0;
      else if (match) inv_q <= match_inv;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      seen_q  <= 1'b0;
      buf_q   <= '0;
    end else if (tx_mode_i) begin
      sync_q  <= 1'b0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (match)            sync_q <= 1'b1;
      else if (rd_status_i) sync_q <= 1'b0;

      if (done) begin
        buf_q   <= byte_w;
        ready_q <= 1'b1;
        seen_q  <= 1'b0;
      end else if (consume) begin
        ready_q <= 1'b0;
        seen_q  <= 1'b0;
      end else if (rd_status_i && ready_q) begin
        seen_q <= 1'b1;
      end

      if (done && ready_q && !consume) ovr_q <= 1'b1;
      else if (rd_status_i)            ovr_q <= 1'b0;
    end
  end

  assign status_o = {2'b00, framing_q, prime_q, inv_q, ovr_q, ready_q, sync_q};
  assign rx_byte_o = buf_q;
  assign irq_o = sync_q || ready_q;

  p_sync_needs_prime_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> $past(prime_q));
  p_prime_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> (!prime_q && framing_q));
  p_ready_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && !rd_data_i && !tx_mode_i) |=> ready_q);
  p_overrun_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(ready_q));
  p_tx_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mode_i |=> (!sync_q && !ready_q && !ovr_q && !framing_q));
endmodule

// File: tb/rx_sync_framer_bench.sv
module rx_sync_framer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 1'b0, bit_valid = 1'b0, bit_d = 1'b0;
  logic wr_en = 1'b0, rd_status = 1'b0, rd_data = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status, rx_byte;
  logic irq;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  rx_sync_framer u_rx_sync_framer (
    .clk_i(clk), .rst_ni(rst_n), .tx_mode_i(tx_mode), .bit_valid_i(bit_valid),
    .bit_i(bit_d), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_status_i(rd_status), .rd_data_i(rd_data), .status_o(status),
    .rx_byte_o(rx_byte), .irq_o(irq)
  );

  // {word, sent stream, expect sync, expect inverted}
  localparam logic [33:0] VEC [6] = '{
    {16'hA5C3, 16'hA5C3, 1'b1, 1'b0},
    {16'hA5C3, 16'h5A3C, 1'b1, 1'b1},
    {16'hA5C3, 16'hA5C2, 1'b0, 1'b0},
    {16'hAAB6, 16'hAAB6, 1'b1, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 1'b1},
    {16'h1234, 16'h1235, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1; bit_d = b;
    @(negedge clk); bit_valid = 0;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic read(input logic st, input logic dt);
    @(negedge clk); rd_status = st; rd_data = dt;
    @(negedge clk); rd_status = 0; rd_data = 0;
  endtask

  task automatic tx_pulse();
    @(negedge clk); tx_mode = 1;
    @(negedge clk); tx_mode = 0;
  endtask

  task automatic load_word(input logic [15:0] w);
    host_wr(2'd0, w[15:8]);
    host_wr(2'd1, w[7:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R4 reset status", status, 8'h00);
    check("R4 reset irq", irq, 1'b0);

    for (int k = 0; k < 6; k++) begin
      tx_pulse();
      load_word(VEC[k][33:18]);
      host_wr(2'd2, 8'h01);
      send_bits(VEC[k][17:2], 16);
      check($sformatf("R1 R2 vec%0d sync", k), status[0], VEC[k][1]);
      check($sformatf("R2 vec%0d inv", k), status[3], VEC[k][0]);
      check($sformatf("R4 vec%0d prime", k), status[4], !VEC[k][1]);
    end
    host_wr(2'd2, 8'h00);
    tx_pulse();

    // R3: unarmed, matching stream ignored
    load_word(16'hA5C3);
    send_bits(16'hA5C3, 16);
    check("R3 no prime no sync", status[0], 1'b0);

    // R3: all-zero word needs 16 fresh bits
    load_word(16'h0000);
    host_wr(2'd2, 8'h01);
    send_bits(16'h0000, 8);
    check("R3 partial window no sync", status[0], 1'b0);
    send_bits(16'h0000, 8);
    check("R4 sync after 16 bits", status[0], 1'b1);
    check("R4 prime auto clear", status[4], 1'b0);
    check("R4 framing set", status[5], 1'b1);
    check("R4 irq", irq, 1'b1);

    read(1, 0);
    check("R5 status read clears sync", status[0], 1'b0);
    check("R5 irq drops", irq, 1'b0);

    send_bits(16'h00C9, 8);
    check("R6 ready", status[1], 1'b1);
    check("R6 byte msb first", rx_byte, 8'hC9);
    check("R6 irq", irq, 1'b1);

    read(0, 1);
    check("R7 data read alone keeps ready", status[1], 1'b1);
    read(1, 0);
    read(0, 1);
    check("R7 status then data clears", status[1], 1'b0);

    send_bits(16'h003E, 8);
    send_bits(16'h0071, 8);
    check("R8 overrun set", status[2], 1'b1);
    check("R8 newest byte kept", rx_byte, 8'h71);
    read(1, 1);
    check("R8 status read clears overrun", status[2], 1'b0);
    check("R7 same-cycle reads clear", status[1], 1'b0);

    send_bits(16'h0055, 8);
    check("R6 next byte", rx_byte, 8'h55);
    tx_pulse();
    check("R9 tx clears flags", status & 8'h27, 8'h00);

    @(negedge clk); tx_mode = 1;
    host_wr(2'd2, 8'h01);
    send_bits(16'h0000, 16);
    check("R9 bits ignored in tx", status[0], 1'b0);
    @(negedge clk); tx_mode = 0;

    // R1: match after noise, only on the final bit
    tx_pulse();
    load_word(16'h1234);
    host_wr(2'd2, 8'h01);
    send_bits(16'h0016, 5);
    send_bits(16'h1234 >> 1, 15);
    check("R1 no early sync", status[0], 1'b0);
    send_bit(1'b0);
    check("R1 sync after noise", status[0], 1'b1);
    check("R2 true polarity", status[3], 1'b0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule